// File: doc/BRIEF.md
# Manchester Serial Receive Decoder

This block recovers frames from a Manchester-coded serial line. It runs from the system clock and advances only on a sample enable that pulses 16 times per bit period. Decoding is tied to the transitions in the middle of each bit. The counter that measures time is re-anchored on every accepted mid-bit edge, so small differences in rate between the transmitter and the receiver do not build up.

A frame has three parts, in this order:
- An optional preamble. Its length and its pattern come from configuration.
- A start-frame delimiter. This is either one coded zero or a long sync pattern.
- 5 to 9 data bits, sent LSB first.

The block checks a falling edge that starts a frame over one quarter of a bit before it accepts it. It raises sticky flags for coding errors and delimiter errors. A frame that completes is delivered as a parallel word with a one-clock strobe.

Line convention (after the optional inversion): the idle line is high. A logical 1 is low for the first half of the bit and high for the second half, so its mid-bit edge rises. A logical 0 is high then low, so its mid-bit edge falls.

Top module: `mc_rx_decoder`

## Requirements
- R1: While `man_en_i` is low, the decoder stays idle. It produces no word and sets no flag, whatever the line does.
- R2: When `inv_i` is high, the line is complemented before preamble, delimiter and data decoding. A frame sent inverted decodes to the same word.
- R3: A falling edge from idle starts a frame only when the line then reads low on 4 consecutive sample ticks. A shorter low pulse is dropped with no output and no flag, and the decoder keeps searching.
- R4: `pre_len_i` = 0 disables the preamble, and the delimiter follows the start directly. `pre_len_i` = N > 0 requires N preamble bits before the delimiter.
- R5: `pre_pat_i` selects the expected preamble bits: 00 means all ones, 01 means all zeros, 10 means 0,1,0,1… and 11 means 1,0,1,0…
- R6: A preamble bit whose mid-bit edge has the wrong direction sends the decoder back to search. No word is produced and no flag is set.
- R7: With `one_bit_sfd_i` high, the delimiter must be one coded 0 (a falling mid-bit edge). A rising edge there sets `sfd_err_o` and aborts the frame.
- R8: With `one_bit_sfd_i` low, the delimiter is a sync pattern. The line is low from the delimiter's start until a rising edge 22 to 26 samples later, and then stays high for the next 22 samples. Any other timing sets `sfd_err_o` and aborts the frame.
- R9: Each data bit takes its value from its mid-bit edge: a rise gives 1 and a fall gives 0. Only edges within ±4 samples of the expected mid-bit point are used. Edges at bit boundaries are ignored.
- R10: If no edge occurs within ±4 samples of an expected mid-bit point (in the preamble, the one-bit delimiter or the data), `code_err_o` is set and the frame is aborted.
- R11: `data_len_i` (5 to 9) bits are assembled LSB first. `valid_o` is high for exactly one clock after the last bit. `data_o` holds the word, with the bits above the length at zero, until the next word.
- R12: `code_err_o` and `sfd_err_o` stay set until `clr_i` is high for one clock, which clears both. `clr_i` takes priority over a new error.
- R13: After reset, `data_o` is 0 and `valid_o`, `code_err_o` and `sfd_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| samp_en_i | input | 1 | Sample tick, 16 per bit period |
| rx_i | input | 1 | Serial line, already synchronous to clk_i |
| man_en_i | input | 1 | Decoder enable |
| inv_i | input | 1 | Complement the line before decoding |
| pre_len_i | input | PLW (4) | Preamble length in bits, 0 means none |
| pre_pat_i | input | 2 | Preamble pattern code |
| one_bit_sfd_i | input | 1 | 1: delimiter is a coded zero, 0: delimiter is the sync pattern |
| data_len_i | input | LW (4) | Data bits per frame, 5 to 9 |
| clr_i | input | 1 | Clears both error flags |
| data_o | output | MAX_DW (9) | Last received word |
| valid_o | output | 1 | One-clock strobe for a new word |
| code_err_o | output | 1 | Sticky flag: missing mid-bit transition |
| sfd_err_o | output | 1 | Sticky flag: bad start-frame delimiter |

## Verification
Frames are sent with every preamble pattern, with no preamble, with both delimiter types, with data lengths of 5, 6, 7, 8 and 9, and with the line inverted. Together these separate errors in pattern decoding, in start alignment (a frame whose first half-bit is low versus one whose first half-bit merges with idle) and in bit ordering. Faulty stimuli are also sent:
- a low pulse shorter than a quarter bit, to check start qualification;
- a preamble bit of the wrong direction, which must be dropped silently;
- a delimiter of the wrong polarity, and a sync pattern that is too short, both of which must set the delimiter flag;
- a line that stops toggling mid-frame, which must set the coding flag.

Every word that appears at the output is matched against a queue of expected words, clock by clock, so any extra or missing word is reported.

// File: rtl/mc_rx_pkg.sv
package mc_rx_pkg;

  typedef enum logic [2:0] {
    ST_SEARCH,
    ST_START,
    ST_PRE,
    ST_SFD1,
    ST_SYNC_LO,
    ST_SYNC_HI,
    ST_DATA
  } mc_state_e;

  // expected preamble bit; odd = position parity
  function automatic logic pre_bit(input logic [1:0] pat, input logic odd);
    case (pat)
      2'b00:   return 1'b1;
      2'b01:   return 1'b0;
      2'b10:   return odd;
      default: return ~odd;
    endcase
  endfunction

endpackage

// File: rtl/mc_line_sampler.sv
module mc_line_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  input  logic inv_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  logic prev_q;

  assign lvl_o  = rx_i ^ inv_i;
  assign rise_o = tick_i & lvl_o & ~prev_q;
  assign fall_o = tick_i & ~lvl_o & prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_q <= 1'b1;
    else if (tick_i) prev_q <= lvl_o;
  end

endmodule

// File: rtl/mc_word_asm.sv
module mc_word_asm #(
  parameter int unsigned MAX_DW = 9,
  parameter int unsigned LW     = $clog2(MAX_DW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_buf_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic [LW-1:0]     len_i,
  output logic              last_o,
  output logic [MAX_DW-1:0] data_o,
  output logic              valid_o
);

  logic [MAX_DW-1:0] buf_q, nxt;
  logic [LW-1:0]     idx_q;

  assign last_o = (idx_q == len_i - LW'(1));

  always_comb begin
    nxt = buf_q;
    if (idx_q < LW'(MAX_DW)) nxt[idx_q] = bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      idx_q   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clr_buf_i) begin
        buf_q <= '0;
        idx_q <= '0;
      end else if (bit_vld_i) begin
        if (last_o) begin
          data_o  <= nxt;
          valid_o <= 1'b1;
          buf_q   <= '0;
          idx_q   <= '0;
        end else begin
          buf_q <= nxt;
          idx_q <= idx_q + LW'(1);
        end
      end
    end
  end

  // R11
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R11
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bit_vld_i));

endmodule

// File: rtl/mc_rx_decoder.sv
module mc_rx_decoder
  import mc_rx_pkg::*;
#(
  parameter int unsigned OS       = 16,
  parameter int unsigned SYNC_TOL = 2,
  parameter int unsigned PLW      = 4,
  parameter int unsigned MAX_DW   = 9,
  parameter int unsigned LW       = $clog2(MAX_DW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_en_i,
  input  logic              rx_i,
  input  logic              man_en_i,
  input  logic              inv_i,
  input  logic [PLW-1:0]    pre_len_i,
  input  logic [1:0]        pre_pat_i,
  input  logic              one_bit_sfd_i,
  input  logic [LW-1:0]     data_len_i,
  input  logic              clr_i,
  output logic [MAX_DW-1:0] data_o,
  output logic              valid_o,
  output logic              code_err_o,
  output logic              sfd_err_o
);

  localparam int unsigned CW = $clog2(2*OS + SYNC_TOL + 2);
  localparam int unsigned QW = $clog2(OS/4 + 1);
  localparam logic [CW-1:0] C_QTR  = CW'(OS/4);
  localparam logic [CW-1:0] C_HALF = CW'(OS/2);
  localparam logic [CW-1:0] C_BND  = CW'(OS/4 + OS/2);
  localparam logic [CW-1:0] C_WLO  = CW'(OS - OS/4);
  localparam logic [CW-1:0] C_WHI  = CW'(OS + OS/4);
  localparam logic [CW-1:0] C_SLO  = CW'(2*OS - SYNC_TOL);
  localparam logic [CW-1:0] C_SHI  = CW'(2*OS + SYNC_TOL);
  localparam logic [CW-1:0] C_HMIN = CW'(3*OS/2 - SYNC_TOL);
  localparam logic [CW-1:0] C_DRL  = CW'(3*OS/2 - SYNC_TOL + 1 - OS);
  localparam logic [QW-1:0] Q_LAST = QW'(OS/4 - 1);

  mc_state_e      st_q, st_d, sfd_st;
  logic [CW-1:0]  cnt_q, cnt_d;   // samples since last mid-bit edge
  logic [QW-1:0]  lcnt_q, lcnt_d;
  logic [PLW-1:0] pcnt_q, pcnt_d;
  logic           lvl, rise, fall, any_edge, win;
  logic           set_cerr, set_serr, bit_vld, frame_go, last;

  mc_line_sampler u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (samp_en_i),
    .rx_i   (rx_i),
    .inv_i  (inv_i),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  mc_word_asm #(.MAX_DW(MAX_DW), .LW(LW)) u_asm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_buf_i (frame_go),
    .bit_vld_i (bit_vld),
    .bit_i     (rise),
    .len_i     (data_len_i),
    .last_o    (last),
    .data_o    (data_o),
    .valid_o   (valid_o)
  );

  assign any_edge = rise | fall;
  assign win      = (cnt_q >= C_WLO) && (cnt_q <= C_WHI);
  assign sfd_st   = one_bit_sfd_i ? ST_SFD1 : ST_SYNC_LO;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    lcnt_d   = lcnt_q;
    pcnt_d   = pcnt_q;
    set_cerr = 1'b0;
    set_serr = 1'b0;
    bit_vld  = 1'b0;
    frame_go = 1'b0;
    if (!man_en_i) begin
      st_d = ST_SEARCH;
    end else if (samp_en_i) begin
      if (cnt_q != '1) cnt_d = cnt_q + CW'(1);
      case (st_q)
        ST_SEARCH: if (fall) begin
          st_d   = ST_START;
          lcnt_d = QW'(1);
        end
        ST_START: begin
          if (lvl) st_d = ST_SEARCH;
          else if (lcnt_q == Q_LAST) begin
            frame_go = 1'b1;
            pcnt_d   = '0;
            // align counter to the first expected half-bit
            if (pre_len_i != '0) begin
              if (pre_bit(pre_pat_i, 1'b0)) begin
                st_d  = ST_PRE;
                cnt_d = C_BND;
              end else begin
                pcnt_d = PLW'(1);
                cnt_d  = C_QTR;
                st_d   = (pre_len_i == PLW'(1)) ? sfd_st : ST_PRE;
              end
            end else if (one_bit_sfd_i) begin
              st_d  = ST_DATA;
              cnt_d = C_QTR;
            end else begin
              st_d  = ST_SYNC_LO;
              cnt_d = C_BND;
            end
          end else lcnt_d = lcnt_q + QW'(1);
        end
        ST_PRE, ST_SFD1, ST_DATA: begin
          if (any_edge && win) begin
            cnt_d = CW'(1);
            if (st_q == ST_PRE) begin
              if (rise != pre_bit(pre_pat_i, pcnt_q[0])) st_d = ST_SEARCH;
              else if ((pcnt_q + PLW'(1)) == pre_len_i) st_d = sfd_st;
              else pcnt_d = pcnt_q + PLW'(1);
            end else if (st_q == ST_SFD1) begin
              if (rise) begin
                set_serr = 1'b1;
                st_d     = ST_SEARCH;
              end else st_d = ST_DATA;
            end else begin
              bit_vld = 1'b1;
              if (last) st_d = ST_SEARCH;
            end
          end else if (cnt_q >= C_WHI) begin
            set_cerr = 1'b1;
            st_d     = ST_SEARCH;
          end
        end
        ST_SYNC_LO: begin
          if (lvl && cnt_q > C_HALF) begin
            if (cnt_q >= C_SLO && cnt_q <= C_SHI) begin
              st_d  = ST_SYNC_HI;
              cnt_d = CW'(1);
            end else begin
              set_serr = 1'b1;
              st_d     = ST_SEARCH;
            end
          end else if (!lvl && cnt_q >= C_SHI) begin
            set_serr = 1'b1;
            st_d     = ST_SEARCH;
          end
        end
        ST_SYNC_HI: begin
          if (!lvl) begin
            set_serr = 1'b1;
            st_d     = ST_SEARCH;
          end else if (cnt_q == C_HMIN) begin
            st_d  = ST_DATA;
            cnt_d = C_DRL;
          end
        end
        default: st_d = ST_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_SEARCH;
      cnt_q      <= '0;
      lcnt_q     <= '0;
      pcnt_q     <= '0;
      code_err_o <= 1'b0;
      sfd_err_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      lcnt_q <= lcnt_d;
      pcnt_q <= pcnt_d;
      if (clr_i) begin
        code_err_o <= 1'b0;
        sfd_err_o  <= 1'b0;
      end else begin
        if (set_cerr) code_err_o <= 1'b1;
        if (set_serr) sfd_err_o  <= 1'b1;
      end
    end
  end

  // R1
  off_no_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !man_en_i |=> !valid_o);

  // R10
  win_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q inside {ST_PRE, ST_SFD1, ST_DATA}) |-> cnt_q <= C_WHI);

  // R12
  cerr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_err_o && !clr_i |=> code_err_o);

  // R12
  serr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfd_err_o && !clr_i |=> sfd_err_o);

  // R12
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !code_err_o && !sfd_err_o);

endmodule

// File: tb/tb_mc_rx_decoder.sv
module tb_mc_rx_decoder;

  localparam int MAX_DW = 9;
  localparam int PLW    = 4;
  localparam int LW     = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic samp_en = 1'b0, rx = 1'b1, man_en = 1'b0, inv = 1'b0;
  logic one_bit = 1'b0, clr = 1'b0;
  logic [PLW-1:0] pre_len = '0;
  logic [1:0]     pre_pat = '0;
  logic [LW-1:0]  dlen = LW'(8);
  logic [MAX_DW-1:0] data_o;
  logic valid_o, code_err_o, sfd_err_o;

  int n_chk = 0, n_fail = 0;
  logic [MAX_DW-1:0] exp_q[$];
  string cur_req = "R13";

  always #10 clk = ~clk;

  mc_rx_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .samp_en_i(samp_en), .rx_i(rx),
    .man_en_i(man_en), .inv_i(inv), .pre_len_i(pre_len), .pre_pat_i(pre_pat),
    .one_bit_sfd_i(one_bit), .data_len_i(dlen), .clr_i(clr),
    .data_o(data_o), .valid_o(valid_o), .code_err_o(code_err_o), .sfd_err_o(sfd_err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // per-clock comparison of delivered words against the model queue
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) chk({cur_req, " unexpected word"}, 32'(data_o), 32'hFFFF);
      else chk({cur_req, " R11 word"}, 32'(data_o), 32'(exp_q.pop_front()));
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL all: watchdog actual expired expected done");
    summary();
    $finish;
  end

  function automatic logic pbit(input logic [1:0] pat, input int k);
    case (pat)
      2'b00:   return 1'b1;
      2'b01:   return 1'b0;
      2'b10:   return k[0];
      default: return ~k[0];
    endcase
  endfunction

  task automatic samp(input logic v);
    @(negedge clk); rx = v ^ inv; samp_en = 1'b1;
    @(negedge clk); samp_en = 1'b0;
  endtask
  task automatic run(input logic v, input int n);
    for (int i = 0; i < n; i++) samp(v);
  endtask
  task automatic mbit(input logic b);
    run(~b, 8); run(b, 8);
  endtask
  task automatic sync_pat();
    run(1'b0, 24); run(1'b1, 24);
  endtask

  task automatic cfg(input int pl, input logic [1:0] pat, input logic ob, input int len);
    @(negedge clk);
    pre_len = PLW'(pl); pre_pat = pat; one_bit = ob; dlen = LW'(len);
  endtask

  task automatic send_frame(input int pl, input logic [1:0] pat, input logic ob,
                            input logic [MAX_DW-1:0] w, input int len);
    for (int k = 0; k < pl; k++) mbit(pbit(pat, k));
    if (ob) mbit(1'b0); else sync_pat();
    for (int i = 0; i < len; i++) mbit(w[i]);
    run(1'b1, 40);
  endtask

  task automatic good(input string req, input int pl, input logic [1:0] pat, input logic ob,
                      input logic [MAX_DW-1:0] w, input int len);
    logic [MAX_DW-1:0] m;
    cur_req = req;
    m = w & MAX_DW'((1 << len) - 1);
    cfg(pl, pat, ob, len);
    exp_q.push_back(m);
    send_frame(pl, pat, ob, w, len);
    chk({req, " word delivered"}, 32'(exp_q.size()), 0);
    chk({req, " no code error"}, 32'(code_err_o), 0);
    chk({req, " no delimiter error"}, 32'(sfd_err_o), 0);
  endtask

  task automatic clear_flags();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R12 clear code flag", 32'(code_err_o), 0);
    chk("R12 clear delimiter flag", 32'(sfd_err_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 data", 32'(data_o), 0);
    chk("R13 valid", 32'(valid_o), 0);
    chk("R13 code flag", 32'(code_err_o), 0);
    chk("R13 delimiter flag", 32'(sfd_err_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    man_en = 1'b1;
    run(1'b1, 10);

    // R4 R8: no preamble, sync delimiter, 8 bits
    good("R8", 0, 2'b00, 1'b0, 9'h0A5, 8);
    // R4 R7: no preamble, coded-zero delimiter, 6 bits
    good("R7", 0, 2'b00, 1'b1, 9'h02D, 6);
    // R5 all ones, R9 boundary edges ignored
    good("R5", 4, 2'b00, 1'b1, 9'h03C, 8);
    // R5 all zeros, sync, 5 bits
    good("R5", 3, 2'b01, 1'b0, 9'h015, 5);
    // R5 0,1,0,1,0 then 9 bits
    good("R9", 5, 2'b10, 1'b1, 9'h1A3, 9);
    chk("R11 data held", 32'(data_o), 32'h1A3);
    // R2 inverted line, pattern 1,0
    @(negedge clk); inv = 1'b1;
    run(1'b1, 10);
    good("R2", 2, 2'b11, 1'b0, 9'h05A, 7);
    @(negedge clk); inv = 1'b0;
    run(1'b1, 10);

    // R6 preamble mismatch: second bit 0 where 1 expected
    cur_req = "R6";
    cfg(4, 2'b00, 1'b1, 8);
    mbit(1'b1); mbit(1'b0); run(1'b1, 40);
    chk("R6 no code flag", 32'(code_err_o), 0);
    chk("R6 no delimiter flag", 32'(sfd_err_o), 0);
    chk("R11 last word kept", 32'(data_o), 32'h05A);
    good("R6", 4, 2'b00, 1'b1, 9'h0C3, 8);

    // R3 short low pulse rejected
    cur_req = "R3";
    cfg(0, 2'b00, 1'b0, 8);
    run(1'b0, 3); run(1'b1, 60);
    chk("R3 no code flag", 32'(code_err_o), 0);
    chk("R3 no delimiter flag", 32'(sfd_err_o), 0);
    good("R3", 0, 2'b00, 1'b0, 9'h071, 8);

    // R10 line stops toggling mid-frame
    cur_req = "R10";
    cfg(0, 2'b00, 1'b1, 8);
    mbit(1'b0); mbit(1'b1); mbit(1'b0); mbit(1'b1);
    run(1'b1, 60);
    chk("R10 code flag set", 32'(code_err_o), 1);
    chk("R10 delimiter flag clear", 32'(sfd_err_o), 0);
    run(1'b1, 20);
    chk("R12 code flag sticky", 32'(code_err_o), 1);
    clear_flags();

    // R8 sync low half too short
    cur_req = "R8";
    cfg(0, 2'b00, 1'b0, 8);
    run(1'b0, 16); run(1'b1, 60);
    chk("R8 delimiter flag set", 32'(sfd_err_o), 1);
    chk("R8 code flag clear", 32'(code_err_o), 0);
    clear_flags();

    // R7 delimiter of wrong polarity after preamble
    cur_req = "R7";
    cfg(2, 2'b00, 1'b1, 8);
    mbit(1'b1); mbit(1'b1); mbit(1'b1); run(1'b1, 60);
    chk("R7 delimiter flag set", 32'(sfd_err_o), 1);
    chk("R7 code flag clear", 32'(code_err_o), 0);
    clear_flags();

    // R1 disabled decoder ignores a valid frame
    cur_req = "R1";
    @(negedge clk); man_en = 1'b0;
    cfg(0, 2'b00, 1'b0, 8);
    send_frame(0, 2'b00, 1'b0, 9'h0FF, 8);
    chk("R1 no code flag", 32'(code_err_o), 0);
    chk("R1 no delimiter flag", 32'(sfd_err_o), 0);
    chk("R1 data unchanged", 32'(data_o), 32'h071);
    @(negedge clk); man_en = 1'b1;
    run(1'b1, 10);
    good("R1", 0, 2'b00, 1'b0, 9'h0E1, 8);

    chk("R11 queue drained", 32'(exp_q.size()), 0);
    summary();
    $finish;
  end

endmodule